// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Prescaler

This block makes the bit clock for a synchronous serial port acting as master. It takes the system clock and divides it in two steps. The first step is a free-running even divider. Its factor comes from an 8-bit setting, and the lowest bit of that setting plays no part. The second step counts ticks of the first one and divides by an 8-bit rate value plus one. A toggle stage after the two dividers drives the serial clock. That clock idles at a level chosen by a polarity input.

Each change of the serial clock comes with a one-cycle strobe. The strobe is tagged as leading (leaving the idle level) or trailing (returning to it), so the shift logic can launch and capture data without detecting clock edges itself. The toggle stage flips at every half period, and the first factor is always even. As a result, one bit period is exactly the product of both factors in system clock cycles, and the duty cycle is exactly half.

The divider settings and the polarity are captured when the enable starts the clock and again at every trailing edge. An update written in the middle of a period therefore never produces a short pulse. Dropping the enable returns the clock to its idle level at once and clears both counters.

Top module: `sclkdiv_prescaler`

## Requirements
- R1: Out of reset `sclk` and `edge_stb` are 0. When `en` is sampled low at a rising edge, the next cycle shows `sclk` equal to the `cpol` value sampled at that edge, with `edge_stb` low.
- R2: The first-stage factor F1 is `pre_div` with bit 0 forced to zero, an even value from 2 to 254. An odd setting gives the same timing as the even setting just below it.
- R3: A `pre_div` of 0 or 1 is treated as F1 = 2, so the clock never stalls.
- R4: While enabled, each half of `sclk` lasts H = F1 × (`rate_sel` + 1) / 2 system cycles. High and low times are equal, and the full period is F1 × (`rate_sel` + 1).
- R5: After the first rising edge that samples `en` high following an idle period, the first `sclk` change appears right after the H-th rising edge that follows it.
- R6: `edge_stb` is high in exactly those cycles in which `sclk` has just changed. In those cycles `edge_lead` is 1 if `sclk` has left the idle level and 0 if it has returned to it.
- R7: `pre_div`, `rate_sel` and `cpol` are captured when the clock starts and at each trailing edge. A change applied at any other time leaves the current period as it is and takes effect from the next full period.
- R8: Dropping `en` for a single cycle clears both counters. The next start then times its first edge as R5 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the clock when high (master operation) |
| pre_div | input | PRE_W | First-stage divisor setting; bit 0 is ignored |
| rate_sel | input | RATE_W | Second-stage rate; divides by value plus one |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial bit clock |
| edge_stb | output | 1 | One-cycle strobe on each `sclk` change |
| edge_lead | output | 1 | Valid with `edge_stb`: 1 leading edge, 0 trailing edge |

## Verification
The bench builds the block with its default widths of eight bits for both settings. This keeps the largest half period, 32512 cycles at a first factor of 254 and a rate of 255, short enough to time edge by edge alongside the small cases. These widths let the bench reach both ends of each range, the zero and odd first-stage settings, and a half period of a single cycle, in which the strobe stays high every cycle.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

    localparam int unsigned DEF_PRE_W  = 8;
    localparam int unsigned DEF_RATE_W = 8;

    typedef enum logic {
        EDGE_TRAIL = 1'b0,
        EDGE_LEAD  = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/sclkdiv_even_stage.sv
module sclkdiv_even_stage #(
    parameter int unsigned HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_i,
    output logic              tick_o
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } even_st_t;

    even_st_t s_q, s_d;
    logic     at_end;

    always_comb begin
        s_d    = s_q;
        at_end = (s_q.cnt == (half_i - HALF_W'(1)));
        if (!run) begin
            s_d.cnt = '0;
        end else if (at_end) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + HALF_W'(1);
        end
        tick_o = run && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_HALF_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.cnt < half_i)); // R2

endmodule

// File: rtl/sclkdiv_rate_stage.sv
module sclkdiv_rate_stage #(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              flip_o
);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } rate_st_t;

    rate_st_t s_q, s_d;
    logic     at_last;

    always_comb begin
        s_d     = s_q;
        at_last = (s_q.cnt == rate_i);
        if (!run) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            s_d.cnt = at_last ? '0 : (s_q.cnt + RATE_W'(1));
        end
        flip_o = tick_i && at_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_RATE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.cnt <= rate_i)); // R4

endmodule

// File: rtl/sclkdiv_toggle.sv
module sclkdiv_toggle
    import sclkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic idle_pol_raw,
    input  logic idle_pol_q,
    input  logic flip_i,
    output logic sclk_o,
    output logic stb_o,
    output logic lead_o,
    output logic period_end_o
);

    typedef struct packed {
        logic       sclk;
        logic       stb;
        edge_kind_e kind;
    } tog_st_t;

    tog_st_t    s_q, s_d;
    edge_kind_e kind_now;

    always_comb begin
        s_d      = s_q;
        s_d.stb  = 1'b0;
        kind_now = (s_q.sclk == idle_pol_q) ? EDGE_LEAD : EDGE_TRAIL;
        if (!en) begin
            s_d.sclk = idle_pol_raw;
        end else if (flip_i) begin
            s_d.sclk = ~s_q.sclk;
            s_d.stb  = 1'b1;
            s_d.kind = kind_now;
        end
        period_end_o = en && flip_i && (kind_now == EDGE_TRAIL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sclk: 1'b0, stb: 1'b0, kind: EDGE_TRAIL};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.sclk;
    assign stb_o  = s_q.stb;
    assign lead_o = (s_q.kind == EDGE_LEAD);

    AST_STB_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> (sclk_o != $past(sclk_o))); // R6

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> ((sclk_o == $past(idle_pol_raw)) && !stb_o)); // R1

endmodule

// File: rtl/sclkdiv_prescaler.sv
module sclkdiv_prescaler
    import sclkdiv_pkg::*;
#(
    parameter int unsigned PRE_W  = DEF_PRE_W,
    parameter int unsigned RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              cpol,
    output logic              sclk,
    output logic              edge_stb,
    output logic              edge_lead
);

    localparam int unsigned HALF_W = PRE_W;

    typedef struct packed {
        logic              active;
        logic [HALF_W-1:0] half;
        logic [RATE_W-1:0] rate;
        logic              pol;
    } top_st_t;

    top_st_t           s_q, s_d;
    logic [HALF_W-1:0] half_raw;
    logic [HALF_W-1:0] half_cand;
    logic              run;
    logic              tick;
    logic              flip;
    logic              period_end;

    always_comb begin
        s_d       = s_q;
        half_raw  = pre_div >> 1;
        half_cand = (half_raw == '0) ? HALF_W'(1) : half_raw;
        run       = en && s_q.active;
        s_d.active = en;
        if (!s_q.active || !en || period_end) begin
            s_d.half = half_cand;
            s_d.rate = rate_sel;
            s_d.pol  = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{active: 1'b0, half: HALF_W'(1), rate: '0, pol: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    sclkdiv_even_stage #(
        .HALF_W (HALF_W)
    ) u_even (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .half_i (s_q.half),
        .tick_o (tick)
    );

    sclkdiv_rate_stage #(
        .RATE_W (RATE_W)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick_i (tick),
        .rate_i (s_q.rate),
        .flip_o (flip)
    );

    sclkdiv_toggle u_toggle (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .idle_pol_raw (cpol),
        .idle_pol_q   (s_q.pol),
        .flip_i       (flip),
        .sclk_o       (sclk),
        .stb_o        (edge_stb),
        .lead_o       (edge_lead),
        .period_end_o (period_end)
    );

    AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && en && !period_end) |=> $stable({s_q.half, s_q.rate, s_q.pol})); // R7

endmodule

// File: tb/sclkdiv_prescaler_bench.sv
module sclkdiv_prescaler_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cpol = 1'b0;
    logic [7:0] pre_div = 8'd2;
    logic [7:0] rate_sel = 8'd0;
    logic       sclk;
    logic       edge_stb;
    logic       edge_lead;

    int checks = 0;
    int failures = 0;
    int stb_errs = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sclkdiv_prescaler u_sclkdiv_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pre_div   (pre_div),
        .rate_sel  (rate_sel),
        .cpol      (cpol),
        .sclk      (sclk),
        .edge_stb  (edge_stb),
        .edge_lead (edge_lead)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int half_len(input logic [7:0] pre, input logic [7:0] rate);
        int f1;
        f1 = int'(pre & 8'hFE);
        if (f1 == 0) f1 = 2;
        return f1 * (int'(rate) + 1) / 2;
    endfunction

    // counts negedge samples until sclk changes; also audits strobe and tag
    task automatic wait_change(input logic pol, output int n);
        logic prev;
        prev = sclk;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (sclk !== prev) begin
                if (edge_stb !== 1'b1 || edge_lead !== (sclk != pol)) stb_errs++;
            end else if (edge_stb !== 1'b0) begin
                stb_errs++;
            end
        end while (sclk === prev && n < 70000);
    endtask

    task automatic t_reset_idle();
        check(sclk === 1'b0, "R1 reset sclk", sclk, 0);
        check(edge_stb === 1'b0, "R1 reset strobe", edge_stb, 0);
        rst_n = 1'b1;
        cpol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(sclk === 1'b1, "R1 idle high", sclk, 1);
        stb_errs = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (edge_stb !== 1'b0 || sclk !== 1'b1) stb_errs++;
        end
        check(stb_errs == 0, "R1 idle quiet", stb_errs, 0);
        cpol = 1'b0;
        @(negedge clk);
        check(sclk === 1'b0, "R1 idle follows polarity", sclk, 0);
    endtask

    task automatic run_case(input logic [7:0] pre, input logic [7:0] rate, input logic pol,
                            input int halves, input string tag);
        int h;
        int n;
        h = half_len(pre, rate);
        en = 1'b0;
        pre_div = pre;
        rate_sel = rate;
        cpol = pol;
        @(negedge clk);
        @(negedge clk);
        check(sclk === pol, {tag, " R1 idle before start"}, sclk, pol);
        stb_errs = 0;
        en = 1'b1;
        wait_change(pol, n);
        check(n == h + 1, {tag, " R5 first edge latency"}, n, h + 1);
        for (int i = 0; i < halves; i++) begin
            wait_change(pol, n);
            check(n == h, {tag, " R4 half period"}, n, h);
        end
        check(stb_errs == 0, {tag, " R6 strobe and tag"}, stb_errs, 0);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_midchange();
        int n;
        en = 1'b0;
        pre_div = 8'd4;
        rate_sel = 8'd3;
        cpol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        wait_change(1'b0, n);
        check(n == 9, "R7 start latency", n, 9);
        pre_div = 8'd10;
        wait_change(1'b0, n);
        check(n == 8, "R7 current period keeps old setting", n, 8);
        wait_change(1'b0, n);
        check(n == 20, "R7 new setting leading half", n, 20);
        wait_change(1'b0, n);
        check(n == 20, "R7 new setting trailing half", n, 20);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_restart();
        int n;
        en = 1'b0;
        pre_div = 8'd6;
        rate_sel = 8'd2;
        cpol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        wait_change(1'b0, n);
        check(n == 10, "R8 initial latency", n, 10);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(sclk === 1'b0 && edge_stb === 1'b0, "R8 drop returns to idle", sclk, 0);
        en = 1'b1;
        wait_change(1'b0, n);
        check(n == 10, "R8 restart from cleared counters", n, 10);
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_idle();
        run_case(8'd2,   8'd0,   1'b0, 4, "R4 minimum");
        run_case(8'd0,   8'd0,   1'b0, 4, "R3 zero setting");
        run_case(8'd1,   8'd0,   1'b1, 4, "R3 setting one");
        run_case(8'd8,   8'd2,   1'b0, 4, "R2 even setting");
        run_case(8'd9,   8'd2,   1'b0, 4, "R2 odd setting");
        run_case(8'd4,   8'd1,   1'b1, 4, "R4 inverted idle");
        run_case(8'd254, 8'd0,   1'b0, 4, "R2 largest first stage");
        run_case(8'd255, 8'd255, 1'b0, 2, "R4 maximum");
        t_midchange();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule